// File: doc/BRIEF.md
# Receive FIFO with trigger level and character timeout

This block is the receive side buffer of a 16550-style serial port. A deserializer hands it one byte per push, or a break indication. The block queues the bytes in a 16-entry first-in first-out store and keeps the data-ready, overrun and break status flags that software sees in the line status register. A byte is consumed through a data-register read strobe. The status flags are acknowledged through a line-status read strobe.

A write port for the FIFO control register sets several things: the buffered or single-byte mode, the trigger level for the receive interrupt, and the flushes of the receive store and of the neighbouring transmit store. The block also watches for data left unread. It measures idle time in character times, which it works out from the current frame format and baud divisor. After four character times with no activity it raises a timeout flag for the interrupt logic.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the FIFO is empty, `fcr_q` is 0x00 (single-byte mode), and `data_ready`, `overrun`, `brk`, `timeout_flag`, `trigger_hit` and `tx_flush` are all 0.
- R2: In buffered mode (`fcr_q` bit 0 = 1), bytes read out in arrival order. `data_ready` is 1 exactly when the count is non-zero. A read of an empty store returns 0x00.
- R3: The store holds 16 bytes. A byte that arrives while it is full and nothing is read is discarded, the stored bytes stay unchanged, and `overrun` becomes 1.
- R4: Control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `trigger_hit` is 1 when buffered mode is on and the count is at least that level.
- R5: A control write keeps only bits 7, 6, 3 and 0, so `fcr_q` equals the written value AND 0xC9.
- R6: A control write with bit 1 set flushes the receive store. A write with bit 2 set pulses `tx_flush` for one cycle. A write that changes bit 0 does both.
- R7: A receive flush empties the store and clears `timeout_flag`.
- R8: The frame length in bits is 1 start bit, plus (`line_fmt`[1:0] + 5) data bits, plus 1 parity bit if `line_fmt`[3] is set, plus 2 stop bits if `line_fmt`[2] is set and 1 otherwise. In buffered mode with a non-empty store, `timeout_flag` rises at the clock edge that completes exactly 64 × divisor × frame bits cycles after the last push or read. A divisor of 0 never raises it.
- R9: A buffered read clears `timeout_flag`. A read that leaves the store empty also clears `data_ready` and `brk`.
- R10: A break push stores 0x00 and sets `brk` and `data_ready`.
- R11: A line-status read clears `brk` and `overrun`. A new setting event in the same cycle wins.
- R12: In single-byte mode one holding byte is used. A new byte replaces it. If `data_ready` was already 1 and the byte is not read in that cycle, `overrun` is set. A read clears `data_ready`.
- R13: A push and a read in the same cycle at a full store are both accepted, and the count stays 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Received byte strobe |
| push_data | input | 8 | Received byte |
| push_break | input | 1 | Break condition received |
| rd_data_req | input | 1 | Data register read strobe |
| rd_data | output | 8 | Byte returned by the current read |
| rd_status_req | input | 1 | Line status register read strobe |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| line_fmt | input | 4 | Frame format: [1:0] data length code, [2] two stop bits, [3] parity on |
| divisor | input | 16 | Baud divisor (one bit time = 16 × divisor cycles) |
| fcr_q | output | 8 | Retained control bits |
| tx_flush | output | 1 | One-cycle transmit store flush request |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | Overrun status |
| brk | output | 1 | Break status |
| timeout_flag | output | 1 | Character timeout pending |
| trigger_hit | output | 1 | Count at or above trigger level |
| fifo_count | output | 5 | Bytes held |

## Verification
The assertions assume that a control write with a flush bit does not come in the same cycle as a push. The flush takes priority, and the bench never makes that overlap. They also assume that `line_fmt` and `divisor` stay fixed while a timeout window is being measured. The directed timeout cases change them only while the store is empty or just before a push. The random phase drives only pushes, reads and status reads in buffered mode with a fixed format.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W        = 8;
    localparam int OVERSAMPLE    = 16;
    localparam int TIMEOUT_CHARS = 4;
    localparam int TICKS_PER_BIT_CHARS = OVERSAMPLE * TIMEOUT_CHARS;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_code_e;

    typedef struct packed {
        trig_code_e trig;
        logic [1:0] spare;
        logic       mode_sel;
        logic       tx_rst;
        logic       rx_rst;
        logic       enable;
    } fcr_t;

    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

    function automatic logic [4:0] trigger_level(trig_code_e c);
        case (c)
            TRIG_ONE:   return 5'd1;
            TRIG_FOUR:  return 5'd4;
            TRIG_EIGHT: return 5'd8;
            default:    return 5'd14;
        endcase
    endfunction

    function automatic logic [3:0] frame_bits(logic [3:0] fmt);
        logic [3:0] n;
        n = 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]};
        n = n + (fmt[2] ? 4'd2 : 4'd1);
        return n;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rd_ptr];

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_no_pop_empty_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
    parameter int LIM_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             restart,
    input  logic             clear,
    input  logic [LIM_W-1:0] limit,
    output logic             flag
);
    logic [LIM_W-1:0] idle_cnt;
    logic [LIM_W-1:0] idle_nxt;

    assign idle_nxt = idle_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            flag     <= 1'b0;
        end else begin
            if (restart || !enable) begin
                idle_cnt <= '0;
            end else if (idle_nxt >= limit) begin
                flag <= 1'b1;
            end else begin
                idle_cnt <= idle_nxt;
            end
            if (clear)
                flag <= 1'b0;
        end
    end

    p_rise_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(enable) && !$past(restart));

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clear |=> !flag);
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int LIM_W = DIV_W + 4 + $clog2(TICKS_PER_BIT_CHARS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [7:0]       push_data,
    input  logic             push_break,
    input  logic             rd_data_req,
    output logic [7:0]       rd_data,
    input  logic             rd_status_req,
    input  logic             fcr_wr,
    input  logic [7:0]       fcr_wdata,
    input  logic [3:0]       line_fmt,
    input  logic [DIV_W-1:0] divisor,
    output logic [7:0]       fcr_q,
    output logic             tx_flush,
    output logic             data_ready,
    output logic             overrun,
    output logic             brk,
    output logic             timeout_flag,
    output logic             trigger_hit,
    output logic [CNT_W-1:0] fifo_count
);
    fcr_t  fcr, fcr_new;
    byte_t hold_q, head, in_byte;
    logic  hold_v, fifo_mode, mode_chg, rx_flush, push_any;
    logic  pop, push_ok, drop, set_ovr, clr_brk, has_room, empty;
    logic [LIM_W-1:0] limit;

    assign fcr_new   = fcr_t'(fcr_wdata);
    assign fifo_mode = fcr.enable;
    assign mode_chg  = fcr_wr && (fcr_new.enable != fcr.enable);
    assign rx_flush  = fcr_wr && (fcr_new.rx_rst || mode_chg);
    assign push_any  = push_valid || push_break;
    assign in_byte   = push_break ? '0 : push_data;
    assign empty     = (fifo_count == '0);

    assign pop      = fifo_mode && rd_data_req && !empty && !rx_flush;
    assign has_room = (fifo_count < CNT_W'(DEPTH)) || pop;
    assign push_ok  = fifo_mode && push_any && !rx_flush && has_room;
    assign drop     = fifo_mode && push_any && !rx_flush && !has_room;
    assign set_ovr  = drop || (!fifo_mode && push_any && hold_v && !rd_data_req);
    assign clr_brk  = rd_status_req
                   || (pop && fifo_count == CNT_W'(1) && !push_ok)
                   || (!fifo_mode && rd_data_req);

    rxq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (push_ok),
        .pop   (pop),
        .din   (in_byte),
        .dout  (head),
        .count (fifo_count)
    );

    assign limit = LIM_W'(frame_bits(line_fmt)) * LIM_W'(divisor)
                 * LIM_W'(TICKS_PER_BIT_CHARS);

    rxq_timeout #(.LIM_W(LIM_W)) u_timeout (
        .clk     (clk),
        .rst     (rst),
        .enable  (fifo_mode && !empty && divisor != '0),
        .restart (push_any || rd_data_req || rx_flush),
        .clear   ((fifo_mode && rd_data_req) || rx_flush),
        .limit   (limit),
        .flag    (timeout_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fcr      <= '0;
            hold_q   <= '0;
            hold_v   <= 1'b0;
            overrun  <= 1'b0;
            brk      <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= fcr_wr && (fcr_new.tx_rst || mode_chg);
            if (fcr_wr)
                fcr <= fcr_t'(fcr_wdata & FCR_KEEP_MASK);
            if (!fifo_mode) begin
                if (push_any) begin
                    hold_q <= in_byte;
                    hold_v <= 1'b1;
                end else if (rd_data_req) begin
                    hold_v <= 1'b0;
                end
            end
            if (set_ovr)
                overrun <= 1'b1;
            else if (rd_status_req)
                overrun <= 1'b0;
            if (push_break)
                brk <= 1'b1;
            else if (clr_brk)
                brk <= 1'b0;
        end
    end

    assign fcr_q       = fcr;
    assign rd_data     = fifo_mode ? (empty ? '0 : head) : hold_q;
    assign data_ready  = fifo_mode ? !empty : hold_v;
    assign trigger_hit = fifo_mode
                      && (int'(fifo_count) >= int'(trigger_level(fcr.trig)));

    p_drop_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        drop |=> overrun && fifo_count == CNT_W'(DEPTH));

    p_mode_flush_r6: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> fifo_count == '0 && tx_flush);

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> !timeout_flag && fifo_count == '0);

    p_status_clear_r11: assert property (@(posedge clk) disable iff (rst)
        rd_status_req && !push_any |=> !brk && !overrun);

    p_break_sets_r10: assert property (@(posedge clk) disable iff (rst)
        push_break |=> brk);

    p_timeout_data_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_flag) |-> $past(fifo_count) != '0);
endmodule

// File: tb/tb_rxq_buffer.sv
module tb_rxq_buffer;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, push_valid, push_break, rd_data_req, rd_status_req, fcr_wr;
    logic [7:0]  push_data, fcr_wdata, rd_data, fcr_q;
    logic [3:0]  line_fmt;
    logic [15:0] divisor;
    logic        tx_flush, data_ready, overrun, brk, timeout_flag, trigger_hit;
    logic [4:0]  fifo_count;

    rxq_buffer dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .push_break(push_break), .rd_data_req(rd_data_req), .rd_data(rd_data),
        .rd_status_req(rd_status_req), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .line_fmt(line_fmt), .divisor(divisor), .fcr_q(fcr_q), .tx_flush(tx_flush),
        .data_ready(data_ready), .overrun(overrun), .brk(brk),
        .timeout_flag(timeout_flag), .trigger_hit(trigger_hit), .fifo_count(fifo_count)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int trig_of(logic [1:0] code);
        case (code)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int window(logic [3:0] fmt, int div);
        int bits;
        bits = 1 + (fmt[1:0] + 5) + (fmt[3] ? 1 : 0) + (fmt[2] ? 2 : 1);
        return bits * div * 64;
    endfunction

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic push_b(logic [7:0] b);
        push_valid = 1; push_data = b; tick(); push_valid = 0;
    endtask

    task automatic push_brk();
        push_break = 1; tick(); push_break = 0;
    endtask

    task automatic rd(output logic [7:0] v);
        rd_data_req = 1; #1; v = rd_data; tick(); rd_data_req = 0;
    endtask

    task automatic stat();
        rd_status_req = 1; tick(); rd_status_req = 0;
    endtask

    task automatic wfcr(logic [7:0] v);
        fcr_wr = 1; fcr_wdata = v; tick(); fcr_wr = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] q[$];
        bit ov;
        int lim;
        rst = 1; push_valid = 0; push_break = 0; rd_data_req = 0; rd_status_req = 0;
        fcr_wr = 0; push_data = 0; fcr_wdata = 0; line_fmt = 0; divisor = 16'd1;
        repeat (3) tick();
        rst = 0; tick();

        // R1 reset state
        check("R1 count", fifo_count, 0);
        check("R1 fcr", fcr_q, 8'h00);
        check("R1 flags", {data_ready, overrun, brk, timeout_flag, trigger_hit, tx_flush}, 0);

        // R5 mask, R6 enable change pulses tx flush
        wfcr(8'hFF);
        check("R5 fcr mask", fcr_q, 8'hC9);
        check("R6 tx_flush on enable change", tx_flush, 1);
        tick();
        check("R6 tx_flush one cycle", tx_flush, 0);

        // R4 trigger levels
        for (int c = 0; c < 4; c++) begin
            wfcr({c[1:0], 6'b000011});
            for (int k = 1; k < trig_of(c[1:0]); k++) push_b(8'(k));
            check("R4 below trigger", trigger_hit, 0);
            push_b(8'hEE);
            check("R4 at trigger", trigger_hit, 1);
        end

        // R2/R3/R13 order, overflow and simultaneous access at full
        wfcr(8'h03);
        for (int i = 0; i < 17; i++) push_b(8'(8'h40 + i));
        check("R3 full count", fifo_count, 16);
        check("R3 overrun set", overrun, 1);
        rd_data_req = 1; push_valid = 1; push_data = 8'h99; #1;
        check("R13 head on simultaneous", rd_data, 8'h40);
        tick(); rd_data_req = 0; push_valid = 0;
        check("R13 count stays full", fifo_count, 16);
        for (int i = 1; i < 16; i++) begin
            rd(v);
            check("R2 order", v, 8'(8'h40 + i));
        end
        rd(v);
        check("R13 pushed byte kept", v, 8'h99);
        check("R2 data_ready empty", data_ready, 0);
        rd(v);
        check("R2 empty read zero", v, 8'h00);
        stat();
        check("R11 overrun cleared", overrun, 0);

        // R10 break, R9 read to empty clears break
        push_brk();
        check("R10 break count", fifo_count, 1);
        check("R10 brk/dr", {brk, data_ready}, 2'b11);
        rd(v);
        check("R10 zero byte", v, 8'h00);
        check("R9 brk/dr cleared", {brk, data_ready}, 2'b00);
        push_brk(); push_b(8'h11);
        stat();
        check("R11 brk cleared", brk, 0);
        check("R11 dr kept", data_ready, 1);
        rd(v); rd(v);
        check("R2 byte after break", v, 8'h11);

        // R8 timeout window, R9 read clears flag
        line_fmt = 4'h0; divisor = 16'd1;
        lim = window(line_fmt, 1);
        push_b(8'h21);
        repeat (lim - 1) tick();
        check("R8 no timeout early", timeout_flag, 0);
        tick();
        check("R8 timeout at window", timeout_flag, 1);
        rd(v);
        check("R9 read clears timeout", timeout_flag, 0);

        line_fmt = 4'hF; divisor = 16'd2;
        lim = window(line_fmt, 2);
        push_b(8'h31); push_b(8'h32);
        repeat (lim - 1) tick();
        check("R8 no timeout early fmt F", timeout_flag, 0);
        tick();
        check("R8 timeout fmt F", timeout_flag, 1);
        wfcr(8'h03);
        check("R7 flush empties", fifo_count, 0);
        check("R7 flush clears timeout", timeout_flag, 0);

        divisor = 16'd0;
        push_b(8'h41);
        repeat (3000) tick();
        check("R8 divisor zero no timeout", timeout_flag, 0);
        divisor = 16'd1; line_fmt = 4'h0;
        wfcr(8'h03);

        // R6 disabling flushes
        push_b(8'h01); push_b(8'h02); push_b(8'h03);
        wfcr(8'h00);
        check("R6 mode change flush", fifo_count, 0);
        check("R6 tx_flush", tx_flush, 1);
        check("R6 dr after disable", data_ready, 0);

        // R12 single-byte mode
        push_b(8'hA5);
        check("R12 dr set", data_ready, 1);
        rd(v);
        check("R12 holding byte", v, 8'hA5);
        check("R12 dr cleared", data_ready, 0);
        push_b(8'h01); push_b(8'h02);
        check("R12 overrun", overrun, 1);
        rd(v);
        check("R12 newest byte", v, 8'h02);
        stat();
        check("R11 overrun cleared", overrun, 0);
        wfcr(8'h04);
        check("R6 tx only", {tx_flush, fcr_q}, {1'b1, 8'h00});

        // Random phase in buffered mode (R2, R3, R11, R13)
        void'($urandom(32'h5EED));
        wfcr(8'h01);
        q.delete(); ov = 0;
        for (int it = 0; it < 800; it++) begin
            int r;
            r = $urandom % 8;
            if (it >= 400) r = (r < 2) ? 0 : (r < 6 ? 4 : r);
            if (r < 4) begin
                logic [7:0] b;
                b = 8'($urandom);
                push_b(b);
                if (q.size() < 16) q.push_back(b); else ov = 1;
            end else if (r < 6) begin
                logic [7:0] e;
                e = (q.size() > 0) ? q.pop_front() : 8'h00;
                rd(v);
                check("R2 random read", v, e);
            end else if (r == 6) begin
                logic [7:0] b, e;
                b = 8'($urandom);
                e = (q.size() > 0) ? q.pop_front() : 8'h00;
                rd_data_req = 1; push_valid = 1; push_data = b; #1;
                v = rd_data; tick(); rd_data_req = 0; push_valid = 0;
                check("R13 random simultaneous read", v, e);
                if (q.size() < 16) q.push_back(b); else ov = 1;
            end else begin
                stat();
                ov = 0;
            end
            check("R3 random count", fifo_count, q.size());
            check("R11 random overrun", overrun, ov);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule